// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block sits between a host register port and the pins of a NAND flash device. The host loads a command byte or an address byte into 16-bit registers. It then writes a single trigger bit into a control register. The sequencer turns that request into one bus operation on the flash pins and reports when it has finished. Six operations are available:

- a command latch cycle;
- an address latch cycle;
- a page program, which streams a page out of the internal buffer;
- a page read, which captures a page into the internal buffer;
- an identification read;
- a status read.

Page and identification transfers always use buffer slot zero. Transfers move bytes over a simple buffer port: an address, a write strobe, write data, and read data that is valid in the same cycle. The buffer memory itself is outside the block.

The host also controls chip selection. A chip-enable bit gates whether any device is selected, and a 2-bit field picks which of four devices is selected. A self-clearing soft reset aborts any running operation and returns every register to its reset value. For page program and page read, the sequencer watches the flash ready/busy line itself, so the host only polls the completion bit.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, every register reads 0. All chip-enable outputs are high, the write and read strobes are high, and the command and address latch outputs are low.
- R2: In the control register (register index 2), a write whose bits 5:0 hold exactly one set bit starts an operation. Bit 0 is command, bit 1 address, bit 2 program, bit 3 page read, bit 4 ID read and bit 5 status read. A write whose bits 5:0 hold zero or several set bits starts nothing.
- R3: Control bit 15 reads 1 once the started operation has finished, and it stays 1 until a control write carries bit 15 as 0. While an operation runs, bits 5:0 read back its trigger bit.
- R4: A command operation drives the low byte of the command register (index 0) with the command latch output high. An address operation drives the low byte of the address register (index 1) with the address latch output high. Each of them makes one write-strobe pulse.
- R5: Every write or read strobe pulse stays low for LOW_CYC clocks. Successive pulses of one transfer are separated by HIGH_CYC clocks high.
- R6: A program operation makes PAGE_BYTES write pulses. They carry buffer bytes of slot 0 at ascending offsets, with both latch outputs low. After the last pulse, completion waits until ready/busy is high.
- R7: A page read waits for ready/busy high before its first read pulse. It then makes PAGE_BYTES read pulses, and each captures the data input into slot 0 at ascending offsets.
- R8: An ID read makes ID_BYTES read pulses and a status read makes one. Both capture into slot 0 from offset 0, and neither waits on ready/busy.
- R9: In the buffer-address register (index 3), the slot field is bits 2:0 and the chip-select field is bits 6:5. Starting a program, page read, ID read or status read clears the slot field. Command and address operations leave it unchanged.
- R10: Chip-enable output i is low only when configuration bit 7 (register index 4) is set and the chip-select field equals i. At most one chip-enable output is low.
- R11: While an operation runs, a control write with a trigger bit neither starts nor changes an operation.
- R12: Writing configuration bit 6 as 1 makes that bit read 1 for RESET_CYC clocks, after which it reads 0. The soft reset aborts any operation and clears every register, including the completion bit and chip enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWe | input | 1 | Host register write strobe |
| hostAddr | input | 3 | Register index (0 command, 1 address, 2 control, 3 buffer address, 4 configuration) |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Read data of the register at hostAddr |
| bufAddr | output | IDX_W+log2(PAGE_BYTES) | Buffer address: slot index above byte offset |
| bufRdData | input | 8 | Buffer read data, valid in the same cycle |
| bufWe | output | 1 | Buffer write strobe for captured bytes |
| bufWdata | output | 8 | Buffer write data |
| nandCeN | output | 4 | Active-low chip enables |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Active-low write strobe |
| nandReN | output | 1 | Active-low read strobe |
| nandDqOut | output | 8 | Flash data bus, outgoing |
| nandDqOe | output | 1 | Output enable for nandDqOut |
| nandDqIn | input | 8 | Flash data bus, incoming |
| nandRb | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
The bench builds the block with:

- PAGE_BYTES = 16
- ID_BYTES = 4
- LOW_CYC = 2
- HIGH_CYC = 3
- RESET_CYC = 5

The short page lets whole program and page-read transfers run many times within a few hundred cycles. It also lets every captured byte be compared against the bench's own buffer model. Unequal low and high phase lengths make a swapped phase counter visible in the measured pulse widths. A short soft-reset window means the exact count of cycles that the reset bit reads 1 can be checked against RESET_CYC directly.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  localparam int TRIG_W   = 6;
  localparam int T_CMD    = 0;
  localparam int T_ADDR   = 1;
  localparam int T_PROG   = 2;
  localparam int T_READ   = 3;
  localparam int T_ID     = 4;
  localparam int T_STAT   = 5;
  localparam int DONE_BIT = 15;
  localparam int CFG_RST  = 6;
  localparam int CFG_CE   = 7;
  localparam int CS_LSB   = 5;

  localparam logic [2:0] REG_CMD  = 3'd0;
  localparam logic [2:0] REG_ADDR = 3'd1;
  localparam logic [2:0] REG_CTRL = 3'd2;
  localparam logic [2:0] REG_BUF  = 3'd3;
  localparam logic [2:0] REG_CFG  = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_WAITRB, S_LOW, S_HIGH} seqState_e;

  typedef struct packed {
    logic setDone;
    logic capture;
    logic dataPhase;
  } strobe_t;
endpackage

// File: rtl/nseq_ctrl.sv
module nseq_ctrl
  import nseq_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int ID_BYTES   = 5,
  parameter int LOW_CYC    = 3,
  parameter int HIGH_CYC   = 2,
  localparam int PAGE_AW   = $clog2(PAGE_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [TRIG_W-1:0]  startOp,
  input  logic               abort,
  input  logic               nandRb,
  output logic               busy,
  output logic [TRIG_W-1:0]  opReg,
  output strobe_t            strobes,
  output logic [PAGE_AW-1:0] byteIdx,
  output logic               cle,
  output logic               ale,
  output logic               weN,
  output logic               reN,
  output logic               dqOe
);
  localparam int PH_MAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW = $clog2(PH_MAX + 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);

  seqState_e state;
  logic [CW-1:0] phCnt;
  logic [PAGE_AW-1:0] lastByte;
  logic isRead, isWrite, lowEnd, highEnd, lastHit, active;

  assign isRead  = opReg[T_READ] | opReg[T_ID] | opReg[T_STAT];
  assign isWrite = opReg[T_CMD] | opReg[T_ADDR] | opReg[T_PROG];
  assign lowEnd  = (state == S_LOW) && (phCnt == LOW_LAST);
  assign highEnd = (state == S_HIGH) && (phCnt == HIGH_LAST);
  assign lastHit = (byteIdx == lastByte);
  assign active  = (state == S_LOW) || (state == S_HIGH);

  always_comb begin
    if (opReg[T_PROG] || opReg[T_READ]) lastByte = PAGE_AW'(PAGE_BYTES - 1);
    else if (opReg[T_ID])                lastByte = PAGE_AW'(ID_BYTES - 1);
    else                                 lastByte = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opReg   <= '0;
      phCnt   <= '0;
      byteIdx <= '0;
    end else if (abort) begin
      state   <= S_IDLE;
      opReg   <= '0;
      phCnt   <= '0;
      byteIdx <= '0;
    end else begin
      case (state)
        S_IDLE: if (startReq) begin
          opReg   <= startOp;
          phCnt   <= '0;
          byteIdx <= '0;
          state   <= startOp[T_READ] ? S_WAITRB : S_LOW;
        end
        S_WAITRB: if (nandRb) begin
          phCnt <= '0;
          if (opReg[T_PROG]) begin
            state <= S_IDLE;
            opReg <= '0;
          end else begin
            state <= S_LOW;
          end
        end
        S_LOW: begin
          if (lowEnd) begin
            state <= S_HIGH;
            phCnt <= '0;
          end else begin
            phCnt <= phCnt + CW'(1);
          end
        end
        S_HIGH: begin
          if (highEnd) begin
            phCnt <= '0;
            if (lastHit) begin
              if (opReg[T_PROG]) state <= S_WAITRB;
              else begin
                state <= S_IDLE;
                opReg <= '0;
              end
            end else begin
              byteIdx <= byteIdx + PAGE_AW'(1);
              state   <= S_LOW;
            end
          end else begin
            phCnt <= phCnt + CW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.setDone   = (highEnd && lastHit && !opReg[T_PROG]) ||
                        ((state == S_WAITRB) && nandRb && opReg[T_PROG]);
    strobes.capture   = lowEnd && isRead;
    strobes.dataPhase = active && opReg[T_PROG];
  end

  assign busy = (state != S_IDLE);
  assign cle  = active && opReg[T_CMD];
  assign ale  = active && opReg[T_ADDR];
  assign weN  = !((state == S_LOW) && isWrite);
  assign reN  = !((state == S_LOW) && isRead);
  assign dqOe = active && isWrite;
endmodule

// File: rtl/nseq_datapath.sv
module nseq_datapath
  import nseq_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int CS_W      = 2,
  parameter int RESET_CYC = 8,
  localparam int CS_COUNT = 1 << CS_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWe,
  input  logic [2:0]          hostAddr,
  input  logic [15:0]         hostWdata,
  output logic [15:0]         hostRdata,
  input  logic                busy,
  input  logic [TRIG_W-1:0]   opReg,
  input  strobe_t             strobes,
  input  logic [7:0]          bufRdData,
  output logic                startReq,
  output logic [TRIG_W-1:0]   startOp,
  output logic                resetting,
  output logic                doneFlag,
  output logic [IDX_W-1:0]    bufIdx,
  output logic [CS_COUNT-1:0] ceN,
  output logic [7:0]          dqOut
);
  localparam int RCW = $clog2(RESET_CYC + 1);
  localparam logic [TRIG_W-1:0] XFER_MASK =
    TRIG_W'((1 << T_PROG) | (1 << T_READ) | (1 << T_ID) | (1 << T_STAT));

  logic [15:0] cmdReg, addrReg;
  logic [CS_W-1:0] csSel;
  logic ceEn;
  logic [RCW-1:0] rstCnt;
  logic wrCtrl, wrBuf, wrCfg, wrCmd, wrAddr;

  assign wrCmd    = hostWe && (hostAddr == REG_CMD) && !resetting;
  assign wrAddr   = hostWe && (hostAddr == REG_ADDR) && !resetting;
  assign wrCtrl   = hostWe && (hostAddr == REG_CTRL) && !resetting;
  assign wrBuf    = hostWe && (hostAddr == REG_BUF) && !resetting;
  assign wrCfg    = hostWe && (hostAddr == REG_CFG) && !resetting;
  assign startOp  = hostWdata[TRIG_W-1:0];
  assign startReq = wrCtrl && !busy && $onehot(startOp);

  // soft reset window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetting <= 1'b0;
      rstCnt    <= '0;
    end else if (resetting) begin
      if (rstCnt == '0) resetting <= 1'b0;
      else              rstCnt    <= rstCnt - RCW'(1);
    end else if (wrCfg && hostWdata[CFG_RST]) begin
      resetting <= 1'b1;
      rstCnt    <= RCW'(RESET_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      addrReg  <= '0;
      doneFlag <= 1'b0;
      bufIdx   <= '0;
      csSel    <= '0;
      ceEn     <= 1'b0;
    end else if (resetting) begin
      cmdReg   <= '0;
      addrReg  <= '0;
      doneFlag <= 1'b0;
      bufIdx   <= '0;
      csSel    <= '0;
      ceEn     <= 1'b0;
    end else begin
      if (wrCmd)  cmdReg  <= hostWdata;
      if (wrAddr) addrReg <= hostWdata;
      if (strobes.setDone)                   doneFlag <= 1'b1;
      else if (wrCtrl && !hostWdata[DONE_BIT]) doneFlag <= 1'b0;
      if (startReq && ((startOp & XFER_MASK) != '0)) bufIdx <= '0;
      else if (wrBuf) bufIdx <= hostWdata[IDX_W-1:0];
      if (wrBuf) csSel <= hostWdata[CS_LSB +: CS_W];
      if (wrCfg) ceEn <= hostWdata[CFG_CE] && !hostWdata[CFG_RST];
    end
  end

  always_comb begin
    hostRdata = '0;
    case (hostAddr)
      REG_CMD:  hostRdata = cmdReg;
      REG_ADDR: hostRdata = addrReg;
      REG_CTRL: begin
        hostRdata[DONE_BIT]     = doneFlag;
        hostRdata[TRIG_W-1:0]   = opReg;
      end
      REG_BUF: begin
        hostRdata[IDX_W-1:0]        = bufIdx;
        hostRdata[CS_LSB +: CS_W]   = csSel;
      end
      REG_CFG: begin
        hostRdata[CFG_CE]  = ceEn;
        hostRdata[CFG_RST] = resetting;
      end
      default: hostRdata = '0;
    endcase
  end

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_ce
    assign ceN[i] = !(ceEn && (csSel == CS_W'(i)));
  end

  always_comb begin
    if (strobes.dataPhase)  dqOut = bufRdData;
    else if (opReg[T_ADDR]) dqOut = addrReg[7:0];
    else                    dqOut = cmdReg[7:0];
  end
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nseq_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int ID_BYTES   = 5,
  parameter int LOW_CYC    = 3,
  parameter int HIGH_CYC   = 2,
  parameter int RESET_CYC  = 8,
  parameter int IDX_W      = 3,
  localparam int CS_W      = 2,
  localparam int CS_COUNT  = 1 << CS_W,
  localparam int PAGE_AW   = $clog2(PAGE_BYTES),
  localparam int BUF_AW    = IDX_W + PAGE_AW
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWe,
  input  logic [2:0]          hostAddr,
  input  logic [15:0]         hostWdata,
  output logic [15:0]         hostRdata,
  output logic [BUF_AW-1:0]   bufAddr,
  input  logic [7:0]          bufRdData,
  output logic                bufWe,
  output logic [7:0]          bufWdata,
  output logic [CS_COUNT-1:0] nandCeN,
  output logic                nandCle,
  output logic                nandAle,
  output logic                nandWeN,
  output logic                nandReN,
  output logic [7:0]          nandDqOut,
  output logic                nandDqOe,
  input  logic [7:0]          nandDqIn,
  input  logic                nandRb
);
  logic busy, startReq, resetting, doneFlag;
  logic [TRIG_W-1:0] opReg, startOp;
  logic [PAGE_AW-1:0] byteIdx;
  logic [IDX_W-1:0] bufIdx;
  strobe_t strobes;

  nseq_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .ID_BYTES(ID_BYTES),
    .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startOp(startOp),
    .abort(resetting), .nandRb(nandRb), .busy(busy), .opReg(opReg),
    .strobes(strobes), .byteIdx(byteIdx), .cle(nandCle), .ale(nandAle),
    .weN(nandWeN), .reN(nandReN), .dqOe(nandDqOe)
  );

  nseq_datapath #(
    .IDX_W(IDX_W), .CS_W(CS_W), .RESET_CYC(RESET_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .busy(busy),
    .opReg(opReg), .strobes(strobes), .bufRdData(bufRdData),
    .startReq(startReq), .startOp(startOp), .resetting(resetting),
    .doneFlag(doneFlag), .bufIdx(bufIdx), .ceN(nandCeN), .dqOut(nandDqOut)
  );

  assign bufAddr  = {bufIdx, byteIdx};
  assign bufWe    = strobes.capture;
  assign bufWdata = nandDqIn;
endmodule

// File: rtl/nand_op_seq_chk.sv
module nand_op_seq_chk #(
  parameter int TW = 6,
  parameter int CSN = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           hostWe,
  input logic [2:0]     hostAddr,
  input logic [15:0]    hostWdata,
  input logic           busy,
  input logic           resetting,
  input logic           doneFlag,
  input logic [TW-1:0]  opReg,
  input logic [CSN-1:0] nandCeN,
  input logic           nandCle,
  input logic           nandAle,
  input logic           nandWeN,
  input logic           nandReN,
  input logic           nandDqOe,
  input logic           bufWe
);
  a_r4_latch_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  a_r10_ce_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~nandCeN));

  a_r5_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  a_r7_capture_in_read: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> (!nandReN && !nandDqOe));

  a_r2_op_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(opReg) && (busy || opReg == '0));

  a_r11_op_stable: assert property (@(posedge clk) disable iff (!rstN || resetting)
    busy |=> (!busy || $stable(opReg)));

  a_r12_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    resetting |=> !busy);

  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !resetting && !(hostWe && hostAddr == 3'd2 && !hostWdata[15]))
      |=> doneFlag);
endmodule

bind nand_op_seq nand_op_seq_chk #(.TW(6), .CSN(4)) u_chk (
  .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
  .hostWdata(hostWdata), .busy(busy), .resetting(resetting),
  .doneFlag(doneFlag), .opReg(opReg), .nandCeN(nandCeN),
  .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
  .nandReN(nandReN), .nandDqOe(nandDqOe), .bufWe(bufWe)
);

// File: tb/nand_op_seq_test.sv
module nand_op_seq_test;
  import nseq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int PB   = 16;
  localparam int IDB  = 4;
  localparam int LC   = 2;
  localparam int HC   = 3;
  localparam int RC   = 5;
  localparam int IDXW = 3;
  localparam int BAW  = IDXW + $clog2(PB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic hostWe = 1'b0;
  logic [2:0] hostAddr = 3'd0;
  logic [15:0] hostWdata = 16'd0;
  logic [15:0] hostRdata;
  logic [BAW-1:0] bufAddr;
  logic [7:0] bufRdData, bufWdata, nandDqOut;
  logic [7:0] nandDqIn = 8'd0;
  logic bufWe, nandCle, nandAle, nandWeN, nandReN, nandDqOe;
  logic nandRb = 1'b1;
  logic [3:0] nandCeN;

  nand_op_seq #(.PAGE_BYTES(PB), .ID_BYTES(IDB), .LOW_CYC(LC),
                .HIGH_CYC(HC), .RESET_CYC(RC), .IDX_W(IDXW)) uut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .bufAddr(bufAddr),
    .bufRdData(bufRdData), .bufWe(bufWe), .bufWdata(bufWdata),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDqOut(nandDqOut),
    .nandDqOe(nandDqOe), .nandDqIn(nandDqIn), .nandRb(nandRb)
  );

  logic [7:0] mem [0:(1<<BAW)-1];
  assign bufRdData = mem[bufAddr];

  int nChecks = 0;
  int nFails = 0;
  int evCnt = 0;
  int reCnt = 0;
  logic [7:0] evDq [0:255];
  logic evCle [0:255];
  logic evAle [0:255];
  int lowLog [0:255];
  int gapLog [0:255];
  int reLowLast = 0;
  logic prevWe = 1'b1, prevRe = 1'b1;
  int weLowRun = 0, weHighRun = 0, reLowRun = 0;

  function automatic logic [7:0] readPattern(input int n);
    return 8'((n * 37 + 11) ^ (n >> 2));
  endfunction

  function automatic logic [3:0] ceExpect(input logic en, input logic [1:0] cs);
    logic [3:0] v;
    v = 4'hF;
    if (en) v[cs] = 1'b0;
    return v;
  endfunction

  // pin monitor: samples away from the active edge
  always @(negedge clk) begin
    if (bufWe) mem[bufAddr] = bufWdata;
    if (!nandWeN) begin
      if (prevWe && evCnt < 256) gapLog[evCnt] = weHighRun;
      weLowRun++;
    end else begin
      if (!prevWe) begin
        if (evCnt < 256) begin
          evDq[evCnt]   = nandDqOut;
          evCle[evCnt]  = nandCle;
          evAle[evCnt]  = nandAle;
          lowLog[evCnt] = weLowRun;
        end
        evCnt++;
        weLowRun = 0;
        weHighRun = 0;
      end
      weHighRun++;
    end
    if (!nandReN) begin
      if (prevRe) begin
        nandDqIn = readPattern(reCnt);
        reCnt++;
        reLowRun = 0;
      end
      reLowRun++;
    end else if (!prevRe) begin
      reLowLast = reLowRun;
    end
    prevWe = nandWeN;
    prevRe = nandReN;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    hostWe = 1'b1;
    hostAddr = a;
    hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    hostAddr = a;
    #1;
    d = hostRdata;
  endtask

  task automatic waitDone(input string tag);
    logic [15:0] r;
    int n;
    n = 0;
    do begin
      regRd(REG_CTRL, r);
      n++;
    end while (!r[15] && n < 3000);
    check(tag, 32'(r[15]), 32'd1);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [15:0] r;
    int e0, r0, hi;
    int unsigned seedVal;
    logic [7:0] b;
    logic isAddr;
    seedVal = $urandom(32'h5EED1234);
    for (int i = 0; i < (1 << BAW); i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRd(REG_CTRL, r);  check("R1 ctrl", 32'(r), 32'h0);
    regRd(REG_CFG, r);   check("R1 cfg", 32'(r), 32'h0);
    regRd(REG_BUF, r);   check("R1 buf", 32'(r), 32'h0);
    check("R1 ce", 32'(nandCeN), 32'hF);
    check("R1 strobes", 32'({nandWeN, nandReN, nandCle, nandAle}), 32'hC);

    // R10 chip enable / select
    regWr(REG_CFG, 16'h0080);
    regWr(REG_BUF, 16'h0040);
    #1 check("R10 cs2", 32'(nandCeN), 32'(ceExpect(1'b1, 2'd2)));
    regWr(REG_BUF, 16'h0060);
    #1 check("R10 cs3", 32'(nandCeN), 32'(ceExpect(1'b1, 2'd3)));
    regWr(REG_CFG, 16'h0000);
    #1 check("R10 disabled", 32'(nandCeN), 32'(ceExpect(1'b0, 2'd3)));
    regWr(REG_CFG, 16'h0080);

    // R4/R5 command cycle, slot field kept (R9)
    regWr(REG_BUF, 16'h0005);
    regWr(REG_CMD, 16'h1290);
    e0 = evCnt;
    regWr(REG_CTRL, 16'h0001);
    waitDone("R3 cmd done");
    check("R4 cmd pulses", 32'(evCnt - e0), 32'd1);
    check("R4 cmd byte", 32'(evDq[e0]), 32'h90);
    check("R4 cmd cle/ale", 32'({evCle[e0], evAle[e0]}), 32'h2);
    check("R5 low width", 32'(lowLog[e0]), 32'(LC));
    regRd(REG_BUF, r);   check("R9 cmd keeps slot", 32'(r), 32'h0005);
    repeat (5) @(negedge clk);
    regRd(REG_CTRL, r);  check("R3 done sticky", 32'(r), 32'h8000);
    regWr(REG_CTRL, 16'h0000);
    regRd(REG_CTRL, r);  check("R3 done cleared", 32'(r), 32'h0);

    // R4 random command / address bytes
    for (int k = 0; k < 8; k++) begin
      b = 8'($urandom);
      isAddr = 1'($urandom);
      regWr(isAddr ? REG_ADDR : REG_CMD, {8'($urandom), b});
      e0 = evCnt;
      regWr(REG_CTRL, isAddr ? 16'h0002 : 16'h0001);
      waitDone("R3 random done");
      check("R4 random byte", 32'(evDq[e0]), 32'(b));
      check("R4 random latch", 32'({evCle[e0], evAle[e0]}), 32'({!isAddr, isAddr}));
      check("R5 random low", 32'(lowLog[e0]), 32'(LC));
    end

    // R2 invalid triggers start nothing
    e0 = evCnt;
    regWr(REG_CTRL, 16'h0003);
    repeat (10) @(negedge clk);
    regRd(REG_CTRL, r);  check("R2 two bits ignored", 32'(r), 32'h0);
    regWr(REG_CTRL, 16'h0000);
    repeat (10) @(negedge clk);
    check("R2 no pulses", 32'(evCnt - e0), 32'd0);

    // R6 program with ready/busy wait, R9 slot cleared, R11 busy writes
    regWr(REG_BUF, 16'h0045);
    nandRb = 1'b0;
    e0 = evCnt;
    regWr(REG_CTRL, 16'h0004);
    regRd(REG_BUF, r);   check("R9 slot cleared", 32'(r), 32'h0040);
    regWr(REG_CTRL, 16'h0001);
    regRd(REG_CTRL, r);  check("R11 op unchanged", 32'(r), 32'h0004);
    while (evCnt - e0 < PB) @(negedge clk);
    repeat (10) @(negedge clk);
    regRd(REG_CTRL, r);  check("R6 waits ready", 32'(r), 32'h0004);
    nandRb = 1'b1;
    waitDone("R6 prog done");
    check("R6 pulse count", 32'(evCnt - e0), 32'(PB));
    hi = 0;
    for (int i = 0; i < PB; i++) begin
      check("R6 prog byte", 32'(evDq[e0 + i]), 32'(mem[i]));
      check("R6 latches low", 32'({evCle[e0 + i], evAle[e0 + i]}), 32'h0);
      if (i > 0 && gapLog[e0 + i] != HC) hi++;
    end
    check("R5 high gaps", 32'(hi), 32'd0);

    // R7 page read waits for ready
    nandRb = 1'b0;
    r0 = reCnt;
    regWr(REG_CTRL, 16'h0008);
    repeat (15) @(negedge clk);
    check("R7 no read while busy", 32'(reCnt - r0), 32'd0);
    regRd(REG_CTRL, r);  check("R7 running", 32'(r), 32'h0008);
    nandRb = 1'b1;
    waitDone("R7 read done");
    check("R7 pulse count", 32'(reCnt - r0), 32'(PB));
    check("R5 read low width", 32'(reLowLast), 32'(LC));
    for (int i = 0; i < PB; i++)
      check("R7 captured byte", 32'(mem[i]), 32'(readPattern(r0 + i)));

    // R8 ID read
    r0 = reCnt;
    b = mem[IDB];
    nandRb = 1'b0;
    regWr(REG_CTRL, 16'h0010);
    waitDone("R8 id done");
    check("R8 id pulses", 32'(reCnt - r0), 32'(IDB));
    for (int i = 0; i < IDB; i++)
      check("R8 id byte", 32'(mem[i]), 32'(readPattern(r0 + i)));
    check("R8 id bound", 32'(mem[IDB]), 32'(b));

    // R8 status read
    r0 = reCnt;
    regWr(REG_CTRL, 16'h0020);
    waitDone("R8 status done");
    check("R8 status pulses", 32'(reCnt - r0), 32'd1);
    check("R8 status byte", 32'(mem[0]), 32'(readPattern(r0)));
    nandRb = 1'b1;

    // R12 soft reset aborts a program
    regWr(REG_CMD, 16'h00AB);
    regWr(REG_BUF, 16'h0020);
    nandRb = 1'b0;
    regWr(REG_CTRL, 16'h0004);
    repeat (6) @(negedge clk);
    regWr(REG_CFG, 16'h00C0);
    hi = 0;
    for (int i = 0; i < RC + 4; i++) begin
      #1;
      if (hostRdata[6]) hi++;
      @(negedge clk);
    end
    check("R12 reset window", 32'(hi), 32'(RC));
    regRd(REG_CFG, r);   check("R12 cfg cleared", 32'(r), 32'h0);
    regRd(REG_CTRL, r);  check("R12 aborted", 32'(r), 32'h0);
    regRd(REG_CMD, r);   check("R12 cmd cleared", 32'(r), 32'h0);
    regRd(REG_BUF, r);   check("R12 buf cleared", 32'(r), 32'h0);
    check("R12 ce off", 32'(nandCeN), 32'hF);
    nandRb = 1'b1;

    finishRun();
  end
endmodule